// File: doc/BRIEF.md
# Back-End Transfer Controller

This block moves single words between a serial-bus terminal core and the user side of a chip: either a linear memory reached through an auto-advancing pointer, or peripherals that the user attaches outside the chip. The core raises a one-cycle request that carries the direction, the addressing mode, a sub-address, a word number and the write data. One shared sequencer then drives a read or write strobe for a fixed number of cycles and ends the transfer with a one-cycle done pulse. Read data is captured from a dedicated input bus. Write data goes out on a separate output bus.

In linear (DMA) mode the address pins carry a 24-bit pointer. Control logic can load and read back this pointer, and it moves forward by one after each DMA transfer. In external-device mode the address pins carry the sub-address and word-number fields instead, and the pointer is left alone. The address outputs are always driven. When no external-device transfer is running, they show the pointer.

Top module: `bkx_xfer`

## Requirements
- R1: While rst_ni is low, addr_o, ptr_rdata_o, rdata_o and dout_o are 0, and rd_stb_o, wr_stb_o, ext_sel_o, busy_o and done_o are low.
- R2: A pointer load (ptr_wr_i high at a clock edge) makes ptr_rdata_o show ptr_wdata_i from the next cycle on. When the block is idle, addr_o shows the same value.
- R3: A request accepted while idle drives exactly one strobe for exactly 2 cycles, starting in the cycle after the request. The strobe is wr_stb_o when req_we_i=1 and rd_stb_o when req_we_i=0. The two strobes are never high together.
- R4: done_o is high for exactly one cycle, the cycle right after the last strobe cycle. busy_o is high from the first strobe cycle through the done cycle and low otherwise.
- R5: On a read, the value of din_i at the last strobe cycle appears on rdata_o from the done cycle on. A write transfer does not change rdata_o.
- R6: During the strobe of a write, dout_o carries the req_wdata_i captured with the request.
- R7: In DMA mode (req_ext_i=0), addr_o equals the pointer throughout the transfer. The pointer increases by one at the end of the done cycle.
- R8: The pointer wraps from 0xFFFFFF to 0x000000.
- R9: In external mode (req_ext_i=1), addr_o during the transfer is the word number in bits [4:0] and the sub-address in bits [9:5], with upper bits 0. ext_sel_o is high during the strobe, and the pointer does not change.
- R10: A pointer load in the same cycle as a pointer increment wins; the loaded value is kept.
- R11: A request raised while busy_o is high is ignored: no further strobe or done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_wr_i | input | 1 | Load pointer |
| ptr_wdata_i | input | 24 | Pointer load value |
| ptr_rdata_o | output | 24 | Pointer read-back |
| req_i | input | 1 | One-cycle transfer request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_ext_i | input | 1 | 1 = external device, 0 = DMA |
| req_sa_i | input | 5 | Sub-address for external mode |
| req_wc_i | input | 5 | Word number for external mode |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last read data |
| addr_o | output | 24 | Address pins, always driven |
| ext_sel_o | output | 1 | External device strobe qualifier |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| dout_o | output | 16 | Write data bus |
| din_i | input | 16 | Read data bus |

## Verification
The assertions check on every cycle that the two strobes exclude each other, that done_o is a single pulse following the last strobe cycle, that a load always beats an increment, and that the pointer changes only through a load or a DMA completion. Only the bench scenarios can show the values: the exact address layout for each sub-address and word number, read data taken at the right edge, wrap at the top of the range, and a request during a transfer leaving no trace.

// File: rtl/bkx_pkg.sv
package bkx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STB  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/bkx_seq.sv
module bkx_seq
  import bkx_pkg::*;
#(
  parameter int unsigned STB_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic stb_o,
  output logic last_stb_o,
  output logic done_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = (STB_CYCLES > 1) ? $clog2(STB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_CYCLES - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    accept_o   = (st_q == ST_IDLE) && req_i;
    stb_o      = (st_q == ST_STB);
    last_stb_o = stb_o && (cnt_q == CNT_LAST);
    done_o     = (st_q == ST_DONE);
    busy_o     = (st_q != ST_IDLE);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d  = ST_STB;
        cnt_d = '0;
      end
      ST_STB: begin
        if (cnt_q == CNT_LAST) st_d = ST_DONE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_stb_o |=> done_o);
  p_stb_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (stb_o && !done_o));
  p_done_from_stb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(stb_o));
endmodule

// File: rtl/bkx_ptr.sv
module bkx_ptr #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  // load has priority over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (wr_i)  ptr_q <= wdata_i;
    else if (inc_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  p_load_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ptr_o == $past(wdata_i)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inc_i) |=> $stable(ptr_o));
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && (&ptr_o)) |=> (ptr_o == '0));
endmodule

// File: rtl/bkx_addr_mux.sv
module bkx_addr_mux #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SA_W   = 5,
  parameter int unsigned WC_W   = 5
) (
  input  logic              ext_i,
  input  logic [SA_W-1:0]   sa_i,
  input  logic [WC_W-1:0]   wc_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned FLD_W = SA_W + WC_W;

  logic [ADDR_W-1:0] ext_addr;

  generate
    if (ADDR_W > FLD_W) begin : g_pad
      assign ext_addr = {{(ADDR_W - FLD_W){1'b0}}, sa_i, wc_i};
    end else begin : g_trunc
      logic [FLD_W-1:0] fld;
      assign fld      = {sa_i, wc_i};
      assign ext_addr = fld[ADDR_W-1:0];
    end
  endgenerate

  assign addr_o = ext_i ? ext_addr : ptr_i;
endmodule

// File: rtl/bkx_xfer.sv
module bkx_xfer #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SA_W       = 5,
  parameter int unsigned WC_W       = 5,
  parameter int unsigned STB_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_wr_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  output logic [ADDR_W-1:0] ptr_rdata_o,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_ext_i,
  input  logic [SA_W-1:0]   req_sa_i,
  input  logic [WC_W-1:0]   req_wc_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ext_sel_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] dout_o,
  input  logic [DATA_W-1:0] din_i
);
  logic              accept, stb, last_stb, done, busy;
  logic              ext_q, we_q;
  logic [SA_W-1:0]   sa_q;
  logic [WC_W-1:0]   wc_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [ADDR_W-1:0] ptr;
  logic              ptr_inc;

  bkx_seq #(.STB_CYCLES(STB_CYCLES)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .accept_o   (accept),
    .stb_o      (stb),
    .last_stb_o (last_stb),
    .done_o     (done),
    .busy_o     (busy)
  );

  // request capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q   <= 1'b0;
      we_q    <= 1'b0;
      sa_q    <= '0;
      wc_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      ext_q   <= req_ext_i;
      we_q    <= req_we_i;
      sa_q    <= req_sa_i;
      wc_q    <= req_wc_i;
      wdata_q <= req_wdata_i;
    end
  end

  // read capture on final strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (last_stb && !we_q) rdata_q <= din_i;
  end

  assign ptr_inc = done && !ext_q;

  bkx_ptr #(.ADDR_W(ADDR_W)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ptr_wr_i),
    .wdata_i (ptr_wdata_i),
    .inc_i   (ptr_inc),
    .ptr_o   (ptr)
  );

  bkx_addr_mux #(.ADDR_W(ADDR_W), .SA_W(SA_W), .WC_W(WC_W)) i_amux (
    .ext_i  (busy && ext_q),
    .sa_i   (sa_q),
    .wc_i   (wc_q),
    .ptr_i  (ptr),
    .addr_o (addr_o)
  );

  assign ptr_rdata_o = ptr;
  assign busy_o      = busy;
  assign done_o      = done;
  assign rdata_o     = rdata_q;
  assign dout_o      = wdata_q;
  assign rd_stb_o    = stb && !we_q;
  assign wr_stb_o    = stb && we_q;
  assign ext_sel_o   = stb && ext_q;

  p_stb_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o && wr_stb_o));
  p_ext_keeps_ptr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_o && !ptr_wr_i) |=> $stable(ptr_rdata_o));
  p_dout_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && !done_o) |=> (!wr_stb_o || $stable(dout_o)));
  p_rdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_o |=> $stable(rdata_o));
endmodule

// File: tb/test_bkx_xfer.sv
module test_bkx_xfer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_wr_i = 1'b0;
  logic [23:0] ptr_wdata_i = '0;
  logic [23:0] ptr_rdata_o;
  logic        req_i = 1'b0, req_we_i = 1'b0, req_ext_i = 1'b0;
  logic [4:0]  req_sa_i = '0, req_wc_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        busy_o, done_o, ext_sel_o, rd_stb_o, wr_stb_o;
  logic [15:0] rdata_o, dout_o;
  logic [15:0] din_i = '0;
  logic [23:0] addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [23:0] exp_ptr = '0;
  logic [15:0] exp_rd  = '0;

  always #10 clk_i = ~clk_i;

  bkx_xfer i_bkx_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i),
    .ptr_rdata_o(ptr_rdata_o), .req_i(req_i), .req_we_i(req_we_i), .req_ext_i(req_ext_i),
    .req_sa_i(req_sa_i), .req_wc_i(req_wc_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .addr_o(addr_o), .ext_sel_o(ext_sel_o),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .dout_o(dout_o), .din_i(din_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ptr_load(input logic [23:0] v);
    ptr_wr_i = 1'b1; ptr_wdata_i = v;
    @(negedge clk_i);
    ptr_wr_i = 1'b0;
    exp_ptr = v;
    chk("R2 ptr readback", 32'(ptr_rdata_o), 32'(v));
    chk("R2 idle addr", 32'(addr_o), 32'(v));
  endtask

  task automatic xfer(input bit ext, input bit we, input logic [4:0] sa, input logic [4:0] wc,
                      input logic [15:0] wd, input logic [15:0] di,
                      input bit busy_req, input bit load_at_done, input logic [23:0] load_val);
    logic [23:0] a_exp;
    a_exp = ext ? {14'd0, sa, wc} : exp_ptr;
    req_i = 1'b1; req_ext_i = ext; req_we_i = we; req_sa_i = sa; req_wc_i = wc; req_wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0; din_i = di;
    if (busy_req) begin
      req_i = 1'b1; req_ext_i = ~ext; req_we_i = ~we; req_wdata_i = ~wd;
    end
    // first strobe cycle
    chk("R3 wr_stb s1", 32'(wr_stb_o), 32'(we));
    chk("R3 rd_stb s1", 32'(rd_stb_o), 32'(!we));
    chk("R4 busy s1", 32'(busy_o), 32'd1);
    chk("R4 done s1", 32'(done_o), 32'd0);
    chk(ext ? "R9 ext addr" : "R7 dma addr", 32'(addr_o), 32'(a_exp));
    chk("R9 ext_sel", 32'(ext_sel_o), 32'(ext));
    if (we) chk("R6 dout", 32'(dout_o), 32'(wd));
    @(negedge clk_i);
    req_i = 1'b0;
    // second strobe cycle
    chk("R3 stb s2", 32'(wr_stb_o | rd_stb_o), 32'd1);
    chk("R4 done s2", 32'(done_o), 32'd0);
    chk(ext ? "R9 ext addr s2" : "R7 dma addr s2", 32'(addr_o), 32'(a_exp));
    if (we) chk("R6 dout s2", 32'(dout_o), 32'(wd));
    @(negedge clk_i);
    // done cycle
    if (!we) exp_rd = di;
    chk("R4 done", 32'(done_o), 32'd1);
    chk("R4 busy done", 32'(busy_o), 32'd1);
    chk("R3 stb off", 32'(wr_stb_o | rd_stb_o), 32'd0);
    chk("R5 rdata", 32'(rdata_o), 32'(exp_rd));
    chk("R9 ptr held in xfer", 32'(ptr_rdata_o), 32'(exp_ptr));
    if (load_at_done) begin
      ptr_wr_i = 1'b1; ptr_wdata_i = load_val;
    end
    @(negedge clk_i);
    ptr_wr_i = 1'b0;
    if (load_at_done) exp_ptr = load_val;
    else if (!ext)    exp_ptr = exp_ptr + 24'd1;
    chk(load_at_done ? "R10 load wins" : (ext ? "R9 ptr kept" : "R7/R8 ptr step"),
        32'(ptr_rdata_o), 32'(exp_ptr));
    chk("R4 done pulse end", 32'(done_o), 32'd0);
    chk("R11 idle after", 32'(busy_o | wr_stb_o | rd_stb_o), 32'd0);
    chk("R2 idle addr", 32'(addr_o), 32'(exp_ptr));
    if (busy_req) begin
      @(negedge clk_i);
      chk("R11 no late stb", 32'(busy_o | wr_stb_o | rd_stb_o | done_o), 32'd0);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 addr", 32'(addr_o), 32'd0);
    chk("R1 ptr", 32'(ptr_rdata_o), 32'd0);
    chk("R1 ctl", 32'({busy_o, done_o, rd_stb_o, wr_stb_o, ext_sel_o}), 32'd0);
    chk("R1 data", 32'({rdata_o, dout_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 24; i++) ptr_load(24'(1) << i);
    ptr_load(24'h5A_C3_0F);

    for (int i = 0; i < 40; i++)
      xfer(1'b0, 1'b0, 5'd0, 5'd0, 16'h0, 16'(i * 16'h1357 + 7), 1'b0, 1'b0, '0);
    for (int i = 0; i < 40; i++)
      xfer(1'b0, 1'b1, 5'd0, 5'd0, 16'(i * 16'h2B1 + 3), 16'hFFFF, 1'b0, 1'b0, '0);

    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 32; w += 7)
        xfer(1'b1, 1'((s + w) & 1), 5'(s), 5'(w), 16'(s * 32 + w), 16'(~(s * 32 + w)),
             1'b0, 1'b0, '0);

    ptr_load(24'hFF_FFFE);
    xfer(1'b0, 1'b0, 5'd0, 5'd0, 16'h0, 16'h1111, 1'b0, 1'b0, '0);
    xfer(1'b0, 1'b1, 5'd0, 5'd0, 16'h2222, 16'h0, 1'b0, 1'b0, '0);
    chk("R8 wrapped", 32'(ptr_rdata_o), 32'd0);
    xfer(1'b0, 1'b0, 5'd0, 5'd0, 16'h0, 16'h3333, 1'b0, 1'b0, '0);

    xfer(1'b0, 1'b0, 5'd0, 5'd0, 16'h0, 16'h4444, 1'b0, 1'b1, 24'h12_3456);
    xfer(1'b0, 1'b1, 5'd0, 5'd0, 16'h5555, 16'h0, 1'b0, 1'b1, 24'hFF_FFFF);
    xfer(1'b1, 1'b0, 5'd9, 5'd3, 16'h0, 16'h6666, 1'b0, 1'b1, 24'h00_0ABC);

    for (int i = 0; i < 8; i++)
      xfer(1'(i & 1), 1'(i >> 1), 5'(i * 3), 5'(i * 5), 16'(i * 16'h0F0F), 16'(i * 16'h3C3C),
           1'b1, 1'b0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule